// File: doc/BRIEF.md
# Software-Managed TLB Write Port

This block is the software access path into a pair of translation lookaside buffer arrays. Each array holds four sets of sixteen entries, and each entry is a 64-bit pair made of a high word (the page tag) and a low word (attributes, including a valid bit). Software never addresses an entry directly. It goes through a small bank of 32-bit special registers: a selector that picks set and index, a high-word mirror, a low-word mirror and a fault-cause register that stages the next high word.

A two-bit bank-select input picks one of four special-register banks. Banks 1 and 2 are tied to the first and second entry array, and register accesses there have side effects. Writing the high mirror also copies the value into the cause register. Writing the low mirror commits a whole entry: the new low word plus the high word held in the cause register. Reading any register first reloads both mirrors from the selected entry. Banks 0 and 3 are plain storage. When a commit replaces an entry whose valid bit was set, the block emits a one-cycle page-flush request carrying the old page address, so the translation cache downstream can drop it.

Top module: `tlb_shadow_port`

## Requirements
- R1: After reset every special register and every entry reads as zero, so all entries are invalid. rdData is zero and flushValid is low.
- R2: With wrEn high, wrData goes into register regAddr of bank bankSel. A later read of that register in that bank returns it. Each of the four banks has its own sixteen registers. A read started with rdEn drives rdData on the clock edge that samples rdEn.
- R3: In banks 0 and 3, writes and reads have no side effects. Writing register 5 or 6 changes neither register 7 nor any entry and never raises flushValid. Reading register 5 or 6 returns the value last written there.
- R4: In bank 1 or 2, a write to register 6 (the high mirror) also stores the same value in register 7 (the fault cause).
- R5: In bank 1 or 2, a write to register 5 (the low mirror) stores the entry chosen by register 4 of that bank. Register 4 bits [5:4] give the set and bits [3:0] give the index. The stored low word is wrData and the stored high word is the current content of register 7. Bank 1 addresses the first array and bank 2 the second.
- R6: In bank 1 or 2, a read of any register first loads register 6 with the selected entry's high word and register 5 with its low word. Reading register 6 or 5 therefore returns the entry's current words.
- R7: A commit (R5) whose replaced entry had low-word bit 3 set raises flushValid for exactly the cycle after the write. flushAddr then equals the old high word with bits [12:0] cleared. A commit over an entry whose bit 3 was clear raises no flush.
- R8: When wrEn and rdEn are both high, only the write takes place, and rdData keeps its previous value.
- R9: rdData holds its value on every cycle in which no read is performed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Active-low synchronous reset |
| wrEn | input | 1 | Write the special register regAddr this cycle |
| rdEn | input | 1 | Read the special register regAddr this cycle |
| bankSel | input | 2 | Special-register bank; 1 and 2 map to the entry arrays |
| regAddr | input | 4 | Special register number |
| wrData | input | 32 | Write data |
| rdData | output | 32 | Read result, registered |
| flushValid | output | 1 | One-cycle page-flush request |
| flushAddr | output | 32 | Page address of the replaced valid entry |

## Verification
The bench targets the ordering hazards. A read of a mirror in bank 1 or 2 must return the entry and not a stale mirror; a design that skipped the reload would echo the last write. A commit must read the old entry before it overwrites it; a design that got this wrong would report the new page, or a flush for an entry that was invalid. The bench also checks that the high word comes from the cause register and not from the high mirror, that banks 0 and 3 and the two arrays stay isolated, and that a simultaneous read and write leaves rdData alone. Random traffic that mixes selector, cause and mirror writes across all banks is compared with a reference model in the bench.

// File: rtl/tlb_port_pkg.sv
package tlb_port_pkg;
  localparam int REG_AW    = 4;
  localparam int NUM_REGS  = 1 << REG_AW;
  localparam int NUM_BANKS = 4;
  localparam int DATA_W    = 32;
  localparam int REG_SEL   = 4;
  localparam int REG_LO    = 5;
  localparam int REG_HI    = 6;
  localparam int REG_CAUSE = 7;

  typedef struct packed {
    logic              plainWr;
    logic              hiWr;
    logic              commit;
    logic              rdGo;
    logic              mirrorLoad;
    logic              tlbBank;
    logic [1:0]        regBank;
    logic [REG_AW-1:0] regIdx;
  } strobe_t;
endpackage

// File: rtl/tlb_port_ctrl.sv
module tlb_port_ctrl
  import tlb_port_pkg::*;
(
  input  logic              wrEn,
  input  logic              rdEn,
  input  logic [1:0]        bankSel,
  input  logic [REG_AW-1:0] regAddr,
  output strobe_t           strb
);
  logic tlbActive;

  always_comb begin
    tlbActive       = (bankSel == 2'd1) || (bankSel == 2'd2);
    strb.regBank    = bankSel;
    strb.regIdx     = regAddr;
    strb.tlbBank    = (bankSel == 2'd2);
    strb.plainWr    = wrEn;
    strb.hiWr       = wrEn && tlbActive && (regAddr == REG_AW'(REG_HI));
    strb.commit     = wrEn && tlbActive && (regAddr == REG_AW'(REG_LO));
    strb.rdGo       = rdEn && !wrEn;
    strb.mirrorLoad = rdEn && !wrEn && tlbActive;
  end
endmodule

// File: rtl/tlb_port_dp.sv
module tlb_port_dp
  import tlb_port_pkg::*;
#(
  parameter int IDX_W      = 4,
  parameter int SET_W      = 2,
  parameter int PAGE_SHIFT = 13
) (
  input  logic              clk,
  input  logic              rstN,
  input  strobe_t           strb,
  input  logic [DATA_W-1:0] wrData,
  output logic [DATA_W-1:0] rdData,
  output logic              flushValid,
  output logic [DATA_W-1:0] flushAddr
);
  localparam int SLOT_W = IDX_W + SET_W;
  localparam int SLOTS  = 1 << SLOT_W;
  localparam int ENT_W  = 2 * DATA_W;

  logic [DATA_W-1:0] sregs [NUM_BANKS][NUM_REGS];
  logic [ENT_W-1:0]  bankView [2];
  logic [DATA_W-1:0] selWord, causeWord, curHi, curLo;
  logic [SLOT_W-1:0] slot;

  always_comb begin
    selWord   = sregs[strb.regBank][REG_SEL];
    causeWord = sregs[strb.regBank][REG_CAUSE];
    slot      = selWord[SLOT_W-1:0];
    curHi     = bankView[strb.tlbBank][ENT_W-1:DATA_W];
    curLo     = bankView[strb.tlbBank][DATA_W-1:0];
  end

  // One entry array per TLB bank
  for (genvar b = 0; b < 2; b++) begin : g_bank
    logic [ENT_W-1:0] ent [SLOTS];
    logic             bankCommit;
    assign bankCommit  = strb.commit && (strb.tlbBank == 1'(b));
    assign bankView[b] = ent[slot];

    always_ff @(posedge clk) begin
      if (!rstN) begin
        for (int s = 0; s < SLOTS; s++) ent[s] <= '0;
      end else if (bankCommit) begin
        ent[slot] <= {causeWord, wrData};
      end
    end
  end

  // Special-register banks with mirror side effects
  always_ff @(posedge clk) begin
    if (!rstN) begin
      for (int k = 0; k < NUM_BANKS; k++)
        for (int r = 0; r < NUM_REGS; r++) sregs[k][r] <= '0;
    end else begin
      if (strb.plainWr) sregs[strb.regBank][strb.regIdx] <= wrData;
      if (strb.hiWr) sregs[strb.regBank][REG_CAUSE] <= wrData;
      if (strb.mirrorLoad) begin
        sregs[strb.regBank][REG_HI] <= curHi;
        sregs[strb.regBank][REG_LO] <= curLo;
      end
    end
  end

  // Read path: reloaded mirrors bypass into the result
  always_ff @(posedge clk) begin
    if (!rstN) begin
      rdData <= '0;
    end else if (strb.rdGo) begin
      if (strb.mirrorLoad && strb.regIdx == REG_AW'(REG_HI))      rdData <= curHi;
      else if (strb.mirrorLoad && strb.regIdx == REG_AW'(REG_LO)) rdData <= curLo;
      else rdData <= sregs[strb.regBank][strb.regIdx];
    end
  end

  // Flush request for a replaced valid entry
  always_ff @(posedge clk) begin
    if (!rstN) begin
      flushValid <= 1'b0;
      flushAddr  <= '0;
    end else begin
      flushValid <= strb.commit && curLo[3];
      if (strb.commit) flushAddr <= (curHi >> PAGE_SHIFT) << PAGE_SHIFT;
    end
  end

  assert_flush_needs_commit_R7: assert property (@(posedge clk) disable iff (!rstN)
    flushValid |-> $past(strb.commit));

  assert_cause_follows_hi_R4: assert property (@(posedge clk) disable iff (!rstN)
    strb.hiWr |=> sregs[$past(strb.regBank)][REG_CAUSE] == $past(wrData));

  assert_mirror_reload_R6: assert property (@(posedge clk) disable iff (!rstN)
    strb.mirrorLoad |=> sregs[$past(strb.regBank)][REG_LO] == $past(curLo));

  assert_read_holds_R9: assert property (@(posedge clk) disable iff (!rstN)
    !strb.rdGo |=> $stable(rdData));

  assert_plain_no_flush_R3: assert property (@(posedge clk) disable iff (!rstN)
    (strb.plainWr && !strb.commit) |=> !flushValid);
endmodule

// File: rtl/tlb_shadow_port.sv
module tlb_shadow_port
  import tlb_port_pkg::*;
#(
  parameter int IDX_W      = 4,
  parameter int SET_W      = 2,
  parameter int PAGE_SHIFT = 13
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        wrEn,
  input  logic        rdEn,
  input  logic [1:0]  bankSel,
  input  logic [3:0]  regAddr,
  input  logic [31:0] wrData,
  output logic [31:0] rdData,
  output logic        flushValid,
  output logic [31:0] flushAddr
);
  strobe_t strb;

  tlb_port_ctrl i_ctrl (
    .wrEn    (wrEn),
    .rdEn    (rdEn),
    .bankSel (bankSel),
    .regAddr (regAddr),
    .strb    (strb)
  );

  tlb_port_dp #(
    .IDX_W      (IDX_W),
    .SET_W      (SET_W),
    .PAGE_SHIFT (PAGE_SHIFT)
  ) i_dp (
    .clk        (clk),
    .rstN       (rstN),
    .strb       (strb),
    .wrData     (wrData),
    .rdData     (rdData),
    .flushValid (flushValid),
    .flushAddr  (flushAddr)
  );
endmodule

// File: tb/test_tlb_shadow_port.sv
`timescale 1ns/1ps
module test_tlb_shadow_port;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        wrEn = 1'b0, rdEn = 1'b0;
  logic [1:0]  bankSel = '0;
  logic [3:0]  regAddr = '0;
  logic [31:0] wrData = '0;
  logic [31:0] rdData, flushAddr;
  logic        flushValid;

  int checks = 0, errors = 0;
  bit done = 1'b0;

  logic [31:0] mReg [4][16];
  logic [63:0] mEnt [2][64];
  logic [31:0] mRd;

  always #2 clk = ~clk;

  tlb_shadow_port i_tlb_shadow_port (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .rdEn(rdEn), .bankSel(bankSel),
    .regAddr(regAddr), .wrData(wrData), .rdData(rdData),
    .flushValid(flushValid), .flushAddr(flushAddr)
  );

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic bit isTlb(logic [1:0] b);
    return (b == 2'd1) || (b == 2'd2);
  endfunction

  // Applies a write to the model; returns the expected flush
  function automatic bit modelWrite(logic [1:0] b, logic [3:0] r, logic [31:0] d,
                                    output logic [31:0] addr);
    logic [63:0] old;
    bit fl = 1'b0;
    addr = '0;
    if (isTlb(b) && r == 4'd5) begin
      old = mEnt[b-1][mReg[b][4][5:0]];
      fl = old[3];
      addr = {old[63:45], 13'b0};
      mEnt[b-1][mReg[b][4][5:0]] = {mReg[b][7], d};
    end
    mReg[b][r] = d;
    if (isTlb(b) && r == 4'd6) mReg[b][7] = d;
    return fl;
  endfunction

  task automatic opWrite(logic [1:0] b, logic [3:0] r, logic [31:0] d, bit alsoRead,
                         string tag);
    logic [31:0] expAddr;
    bit expFl;
    expFl = modelWrite(b, r, d, expAddr);
    @(negedge clk);
    wrEn = 1'b1; rdEn = alsoRead; bankSel = b; regAddr = r; wrData = d;
    @(negedge clk);
    wrEn = 1'b0; rdEn = 1'b0;
    chk({tag, " flushValid"}, 32'(flushValid), 32'(expFl));
    if (expFl) chk({tag, " flushAddr"}, flushAddr, expAddr);
    if (alsoRead) chk("R8 rdData kept on write+read", rdData, mRd);
  endtask

  task automatic opRead(logic [1:0] b, logic [3:0] r, string tag);
    if (isTlb(b)) begin
      mReg[b][6] = mEnt[b-1][mReg[b][4][5:0]][63:32];
      mReg[b][5] = mEnt[b-1][mReg[b][4][5:0]][31:0];
    end
    mRd = mReg[b][r];
    @(negedge clk);
    rdEn = 1'b1; bankSel = b; regAddr = r;
    @(negedge clk);
    rdEn = 1'b0;
    chk(tag, rdData, mRd);
    @(negedge clk);
    chk("R9 rdData held while idle", rdData, mRd);
  endtask

  initial begin
    #(4 * 150000);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual=hung expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h5eed_71b0));
    for (int k = 0; k < 4; k++) for (int r = 0; r < 16; r++) mReg[k][r] = '0;
    for (int k = 0; k < 2; k++) for (int s = 0; s < 64; s++) mEnt[k][s] = '0;
    mRd = '0;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    chk("R1 rdData after reset", rdData, 32'h0);
    chk("R1 flushValid after reset", 32'(flushValid), 32'h0);
    opRead(2'd1, 4'd6, "R1 entry high zero after reset");
    opRead(2'd2, 4'd5, "R1 entry low zero after reset");

    // R2 plain storage, banks separate
    opWrite(2'd0, 4'd3, 32'hCAFE0001, 1'b0, "R2");
    opWrite(2'd3, 4'd3, 32'hBEEF0003, 1'b0, "R2");
    opRead(2'd0, 4'd3, "R2 bank0 readback");
    opRead(2'd3, 4'd3, "R2 bank3 readback");

    // R3 no side effects in bank 0
    opWrite(2'd0, 4'd6, 32'h11112222, 1'b0, "R3");
    opRead(2'd0, 4'd7, "R3 cause untouched in bank0");
    opWrite(2'd0, 4'd5, 32'h0000FFFF, 1'b0, "R3 no flush");
    opRead(2'd0, 4'd5, "R3 no reload in bank0");

    // R4/R5/R6 in bank 1, set 2 index 5
    opWrite(2'd1, 4'd4, 32'h00000025, 1'b0, "R2");
    opWrite(2'd1, 4'd6, 32'hABCDE000, 1'b0, "R4");
    opRead(2'd1, 4'd7, "R4 cause copy");
    opWrite(2'd1, 4'd6, 32'h99990000, 1'b0, "R4");
    opWrite(2'd1, 4'd7, 32'hABCDE000, 1'b0, "R5 stage via cause");
    opWrite(2'd1, 4'd5, 32'h00000008, 1'b0, "R7 no flush on invalid");
    opWrite(2'd1, 4'd4, 32'h00000015, 1'b0, "R2");
    opRead(2'd1, 4'd6, "R5 other slot untouched");
    opWrite(2'd1, 4'd4, 32'h00000025, 1'b0, "R2");
    opRead(2'd1, 4'd6, "R6 high reload");
    opRead(2'd1, 4'd5, "R6 low reload");
    opWrite(2'd2, 4'd4, 32'h00000025, 1'b0, "R2");
    opRead(2'd2, 4'd6, "R5 second array separate");

    // R7 flush of a valid replaced entry
    opWrite(2'd1, 4'd6, 32'h12345678, 1'b0, "R4");
    opWrite(2'd1, 4'd5, 32'h00000000, 1'b0, "R7 flush valid old");
    opWrite(2'd1, 4'd5, 32'h000000F7, 1'b0, "R7 no flush invalid old");

    // R8 write wins over read
    opRead(2'd3, 4'd3, "R2 bank3 readback");
    opWrite(2'd3, 4'd9, 32'h76543210, 1'b1, "R8");
    opRead(2'd3, 4'd9, "R8 write landed");

    // Random traffic
    for (int n = 0; n < 700; n++) begin
      logic [1:0]  b;
      logic [3:0]  r;
      logic [31:0] d;
      b = 2'($urandom % 4);
      r = ($urandom % 3 == 0) ? 4'($urandom % 16) : 4'(4 + $urandom % 4);
      d = $urandom;
      if ($urandom % 3 == 0) opRead(b, r, "R6 random read");
      else opWrite(b, r, d, ($urandom % 8 == 0), "R7 random write");
    end

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule